// File: doc/BRIEF.md
# Indirect MMD Register Access Sequencer

This block turns one request for a register inside a PHY's MMD space into the fixed chain of four Clause 22 transactions that reach that space indirectly. Clause 22 register 13 is the MMD access control register and register 14 is the address/data register. The caller gives a PHY address, an MMD device number, a 16-bit MMD register address, a direction and, for writes, the data. A one-cycle start strobe begins the access. When the chain is complete the block raises `done` for one cycle. For a read, the register value is then on `rd_data`.

The block does not shift MDIO bits itself. It issues one transaction at a time to a Clause 22 frame engine over a valid/ready channel. A transaction is accepted in any cycle where `c22_valid` and `c22_ready` are both high. For a read transaction, the engine must present the returned register value on `c22_rdata` in that same cycle. The engine may hold `c22_ready` low for any number of cycles. While it does, the block keeps the pending transaction and all its fields stable.

The block lets nothing else onto the channel while it works. The four transactions are offered back to back, with no idle cycle between them. This keeps another access from changing register 13 or 14 partway through the chain. The `post_incr` input chooses the data-mode function code. The default, low, selects data access without post-increment.

Top module: `mmd_indirect_seq`

## Requirements
- R1: After reset, `busy`, `done` and `c22_valid` are 0 and `rd_data` is 0.
- R2: A start seen while idle latches all operands. In the next cycle the first transaction is offered: a write of register 13 with the device number in bits 4:0 and function bits 15:14 = 00 (for example, device 7 gives 0x0007). Operand changes after the start cycle have no effect.
- R3: The second transaction writes register 14 with the MMD register address.
- R4: The third transaction writes register 13 with the device number ORed with the data-mode function code. The code is 0x4000 (bits 15:14 = 01) when `post_incr`=0 and 0x8000 (bits 15:14 = 10) when `post_incr`=1.
- R5: The fourth transaction reads register 14 for a read (`op_write`=0). For a write (`op_write`=1) it writes register 14 with `wdata`.
- R6: While `c22_valid` is high and `c22_ready` is low, the transaction and all its fields stay unchanged. The sequence advances only on a handshake.
- R7: `c22_valid` stays high without a gap from the first transaction until the fourth handshake. Every transaction carries the latched PHY address. Each access produces exactly four handshakes.
- R8: `busy` is high from the cycle after an accepted start until the fourth handshake. `done` is a single-cycle pulse in the cycle after the fourth handshake, and `busy` is low in that cycle.
- R9: On the fourth handshake of a read, `c22_rdata` is captured into `rd_data`. `rd_data` then holds until the next read completes. A write access leaves `rd_data` unchanged.
- R10: A start while `busy` is ignored. The running access keeps its operands and no extra transactions follow. A start in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one access (taken only when idle) |
| phy_addr | input | 5 | Target PHY address |
| mmd_dev | input | 5 | MMD device number |
| mmd_addr | input | 16 | MMD register address |
| op_write | input | 1 | 1 = write access, 0 = read access |
| wdata | input | 16 | Data for a write access |
| post_incr | input | 1 | 1 = data mode with post-increment, 0 = without |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Result of the last read access |
| c22_valid | output | 1 | Transaction offered to the Clause 22 engine |
| c22_ready | input | 1 | Engine accepts the offered transaction |
| c22_write | output | 1 | 1 = write transaction, 0 = read |
| c22_phy | output | 5 | PHY address of the transaction |
| c22_reg | output | 5 | Clause 22 register number (13 or 14) |
| c22_wdata | output | 16 | Write data of the transaction (0 for reads) |
| c22_rdata | input | 16 | Read data, valid on a read handshake |

## Verification
The hardest situation to reach from the ports is a new start arriving mid-chain while the engine is stalling, combined with operands that change right after acceptance. The bench drives `c22_ready` with a random pattern and changes every operand input on the cycle after each start. It also pulses start again with different operands while the access runs, and issues the next access in the `done` cycle. A behavioural model tracks the expected step and payload on every cycle, so any leaked operand, extra transaction or lost stall shows up at once.

// File: rtl/mmd_seq_pkg.sv
package mmd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_CTL,
    ST_ADDR_DAT,
    ST_DATA_CTL,
    ST_DATA_XFER
  } seq_st_t;

  localparam logic [4:0] C22_CTRL_REG = 5'd13;
  localparam logic [4:0] C22_DATA_REG = 5'd14;

  localparam logic [1:0] FN_ADDR     = 2'b00;
  localparam logic [1:0] FN_DATA_FIX = 2'b01;
  localparam logic [1:0] FN_DATA_INC = 2'b10;
endpackage

// File: rtl/mmd_step_ctrl.sv
module mmd_step_ctrl
  import mmd_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    ready,
  output seq_st_t st,
  output logic    accept,
  output logic    valid,
  output logic    busy,
  output logic    done,
  output logic    last_hs
);
  seq_st_t st_q, st_d;
  logic    done_q;
  logic    hs;

  assign valid   = (st_q != ST_IDLE);
  assign busy    = valid;
  assign accept  = (st_q == ST_IDLE) && start;
  assign hs      = valid && ready;
  assign last_hs = hs && (st_q == ST_DATA_XFER);
  assign st      = st_q;
  assign done    = done_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (start) st_d = ST_ADDR_CTL;
      ST_ADDR_CTL:  if (hs)    st_d = ST_ADDR_DAT;
      ST_ADDR_DAT:  if (hs)    st_d = ST_DATA_CTL;
      ST_DATA_CTL:  if (hs)    st_d = ST_DATA_XFER;
      ST_DATA_XFER: if (hs)    st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= last_hs;
    end
  end

  // R6: a stalled step does not move
  p_stall_holds_r6: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(st_q));
  // R8: completion is a single pulse with busy low
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy ##1 !done);
  // R10: a start during an access cannot end or restart it
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    busy && start && !ready |=> busy && $stable(st_q));
endmodule

// File: rtl/mmd_req_build.sv
module mmd_req_build
  import mmd_seq_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_st_t           st,
  input  logic              ready,
  input  logic [DEV_W-1:0]  dev,
  input  logic [DATA_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wval,
  input  logic              incr,
  output logic              req_write,
  output logic [4:0]        req_reg,
  output logic [DATA_W-1:0] req_data
);
  localparam int PAD_W = DATA_W - 2 - DEV_W;

  logic [DATA_W-1:0] ctl_addr_word;
  logic [DATA_W-1:0] ctl_data_word;
  logic [1:0]        data_fn;

  assign data_fn = incr ? FN_DATA_INC : FN_DATA_FIX;

  generate
    if (PAD_W > 0) begin : g_pad
      assign ctl_addr_word = {FN_ADDR, {PAD_W{1'b0}}, dev};
      assign ctl_data_word = {data_fn, {PAD_W{1'b0}}, dev};
    end else begin : g_nopad
      assign ctl_addr_word = {FN_ADDR, dev};
      assign ctl_data_word = {data_fn, dev};
    end
  endgenerate

  always_comb begin
    req_write = 1'b1;
    req_reg   = C22_CTRL_REG;
    req_data  = '0;
    unique case (st)
      ST_ADDR_CTL: req_data = ctl_addr_word;
      ST_ADDR_DAT: begin
        req_reg  = C22_DATA_REG;
        req_data = addr;
      end
      ST_DATA_CTL: req_data = ctl_data_word;
      ST_DATA_XFER: begin
        req_reg   = C22_DATA_REG;
        req_write = wr;
        req_data  = wr ? wval : '0;
      end
      default: ;
    endcase
  end

  // R6: offered payload frozen while the engine stalls
  p_payload_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) && !ready |=> $stable({req_write, req_reg, req_data}));
  // R5: a read only ever targets the data register
  p_read_data_reg_r5: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) && !req_write |-> req_reg == C22_DATA_REG);
  // R4: a control word never carries function code 11
  p_ctrl_fn_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) && req_reg == C22_CTRL_REG |-> req_data[DATA_W-1:DATA_W-2] != 2'b11);
endmodule

// File: rtl/mmd_indirect_seq.sv
module mmd_indirect_seq
  import mmd_seq_pkg::*;
#(
  parameter int PHY_W  = 5,
  parameter int DEV_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PHY_W-1:0]  phy_addr,
  input  logic [DEV_W-1:0]  mmd_dev,
  input  logic [DATA_W-1:0] mmd_addr,
  input  logic              op_write,
  input  logic [DATA_W-1:0] wdata,
  input  logic              post_incr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              c22_valid,
  input  logic              c22_ready,
  output logic              c22_write,
  output logic [PHY_W-1:0]  c22_phy,
  output logic [4:0]        c22_reg,
  output logic [DATA_W-1:0] c22_wdata,
  input  logic [DATA_W-1:0] c22_rdata
);
  seq_st_t           st;
  logic              accept;
  logic              last_hs;
  logic [PHY_W-1:0]  phy_q;
  logic [DEV_W-1:0]  dev_q;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] wval_q;
  logic              wr_q;
  logic              incr_q;
  logic [DATA_W-1:0] rd_q;

  mmd_step_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ready   (c22_ready),
    .st      (st),
    .accept  (accept),
    .valid   (c22_valid),
    .busy    (busy),
    .done    (done),
    .last_hs (last_hs)
  );

  mmd_req_build #(.DEV_W(DEV_W), .DATA_W(DATA_W)) u_build (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .ready     (c22_ready),
    .dev       (dev_q),
    .addr      (addr_q),
    .wr        (wr_q),
    .wval      (wval_q),
    .incr      (incr_q),
    .req_write (c22_write),
    .req_reg   (c22_reg),
    .req_data  (c22_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_q  <= '0;
      dev_q  <= '0;
      addr_q <= '0;
      wval_q <= '0;
      wr_q   <= 1'b0;
      incr_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (accept) begin
        phy_q  <= phy_addr;
        dev_q  <= mmd_dev;
        addr_q <= mmd_addr;
        wval_q <= wdata;
        wr_q   <= op_write;
        incr_q <= post_incr;
      end
      if (last_hs && !wr_q) rd_q <= c22_rdata;
    end
  end

  assign c22_phy = phy_q;
  assign rd_data = rd_q;

  // R9: the result only moves when an access completes
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rd_data));
  // R7: PHY address constant across the whole chain
  p_phy_const_r7: assert property (@(posedge clk) disable iff (rst)
    c22_valid && $past(c22_valid) |-> $stable(c22_phy));
  // R7: no gap between steps
  p_no_gap_r7: assert property (@(posedge clk) disable iff (rst)
    c22_valid && !(c22_ready && c22_reg == C22_DATA_REG && !$isunknown(st) && st == ST_DATA_XFER) |=> c22_valid);
endmodule

// File: tb/sim_mmd_indirect_seq.sv
module sim_mmd_indirect_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  mmd_dev = '0;
  logic [15:0] mmd_addr = '0;
  logic        op_write = 1'b0;
  logic [15:0] wdata = '0;
  logic        post_incr = 1'b0;
  logic        busy, done, c22_valid, c22_write;
  logic [15:0] rd_data, c22_wdata;
  logic        c22_ready = 1'b0;
  logic [4:0]  c22_phy, c22_reg;
  logic [15:0] c22_rdata = '0;

  always #2 clk = ~clk;

  mmd_indirect_seq u0 (
    .clk(clk), .rst(rst), .start(start), .phy_addr(phy_addr), .mmd_dev(mmd_dev),
    .mmd_addr(mmd_addr), .op_write(op_write), .wdata(wdata), .post_incr(post_incr),
    .busy(busy), .done(done), .rd_data(rd_data), .c22_valid(c22_valid),
    .c22_ready(c22_ready), .c22_write(c22_write), .c22_phy(c22_phy), .c22_reg(c22_reg),
    .c22_wdata(c22_wdata), .c22_rdata(c22_rdata)
  );

  int checks = 0;
  int failures = 0;
  int ready_mode = 1;
  bit extra_start = 0;
  bit finished = 0;

  // behavioural reference
  int          m_step = 0;
  bit          m_done = 0;
  int          m_rd = 0;
  int          m_phy, m_dev, m_addr, m_wd;
  bit          m_wr, m_inc;
  int          hs_count = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_done = 0; m_rd = 0;
    end else begin
      m_done = 0;
      if (m_step == 0) begin
        if (start) begin
          m_step = 1; m_phy = phy_addr; m_dev = mmd_dev; m_addr = mmd_addr;
          m_wd = wdata; m_wr = op_write; m_inc = post_incr; hs_count = 0;
          extra_start = 0;
        end
      end else if (c22_ready) begin
        hs_count++;
        if (m_step == 4) begin
          if (!m_wr) m_rd = c22_rdata;
          m_done = 1; m_step = 0;
        end else m_step++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      string sfx;
      sfx = extra_start ? " R10" : "";
      if (rst) begin
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(c22_valid == 0, "R1 valid", c22_valid, 0);
        chk(rd_data == 0, "R1 rd_data", rd_data, 0);
      end else begin
        chk(busy == (m_step != 0), "R8 busy", busy, m_step != 0);
        chk(done == m_done, "R8 done", done, m_done);
        chk(c22_valid == (m_step != 0), {"R7 valid", sfx}, c22_valid, m_step != 0);
        chk(rd_data == m_rd[15:0], "R9 rd_data", rd_data, m_rd);
        if (m_done) chk(hs_count == 4, {"R7 handshake count", sfx}, hs_count, 4);
        if (m_step != 0) begin
          chk(c22_phy == m_phy[4:0], {"R7 phy", sfx}, c22_phy, m_phy);
          case (m_step)
            1: begin
              chk(c22_reg == 13 && c22_write, {"R2 reg/dir", sfx}, c22_reg, 13);
              chk(c22_wdata == m_dev[15:0], {"R2 data", sfx}, c22_wdata, m_dev);
            end
            2: begin
              chk(c22_reg == 14 && c22_write, {"R3 reg/dir", sfx}, c22_reg, 14);
              chk(c22_wdata == m_addr[15:0], {"R3 data", sfx}, c22_wdata, m_addr);
            end
            3: begin
              int e;
              e = m_dev | (m_inc ? 'h8000 : 'h4000);
              chk(c22_reg == 13 && c22_write, {"R4 reg/dir", sfx}, c22_reg, 13);
              chk(c22_wdata == e[15:0], {"R4 data", sfx}, c22_wdata, e);
            end
            default: begin
              chk(c22_reg == 14, {"R5 reg", sfx}, c22_reg, 14);
              chk(c22_write == m_wr, {"R5 dir", sfx}, c22_write, m_wr);
              if (m_wr) chk(c22_wdata == m_wd[15:0], {"R5 wdata", sfx}, c22_wdata, m_wd);
            end
          endcase
          if (!c22_ready) chk(1'b1, "R6 stall observed", 0, 0);
        end
      end
      c22_ready = (ready_mode == 1) ? 1'b1 : (($urandom % 3) != 0);
      c22_rdata = 16'($urandom);
    end
  end

  task automatic run_op(input int phy, input int dev, input int addr, input bit wr,
                        input int wd, input bit inc, input bit poke);
    start = 1; phy_addr = 5'(phy); mmd_dev = 5'(dev); mmd_addr = 16'(addr);
    op_write = wr; wdata = 16'(wd); post_incr = inc;
    @(negedge clk);
    start = 0;
    // R2: scramble operands after acceptance
    phy_addr = 5'($urandom); mmd_dev = 5'($urandom); mmd_addr = 16'($urandom);
    op_write = ~wr; wdata = 16'($urandom); post_incr = ~inc;
    if (poke) begin
      @(negedge clk);
      extra_start = 1;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (m_step != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    ready_mode = 1;
    run_op(3, 7, 'h3C, 0, 0, 1, 0);
    run_op(3, 7, 'h3D, 0, 0, 1, 0);
    run_op(9, 1, 'h0000, 0, 0, 0, 0);
    run_op(31, 31, 'hFFFF, 1, 'hA5C3, 0, 0);
    ready_mode = 0;
    for (int i = 0; i < 40; i++)
      run_op($urandom % 32, $urandom % 32, $urandom % 65536, $urandom % 2,
             $urandom % 65536, $urandom % 2, (i % 4) == 0);
    run_op(5, 3, 'h1234, 1, 'hBEEF, 1, 1);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    finished = 1;
    failures++;
    checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule